// File: doc/BRIEF.md
# Bus Failure Diagnostic Flag Logic

This block sits beside the driver and receiver of a differential two-wire bus transceiver. It watches the transmit path while the driver is enabled and keeps a set of sticky diagnostic flags. The flags cover four faults. Transmitted edges that never come back on the receive data raise a bus error. Driver currents that are too low or too high are checked on each of the four output stages. Open lines and shorts to either supply rail are derived from those current flags. A short between the two lines, a driver left enabled too long, and over-temperature are flagged as well. Analog comparators outside the block supply every current, voltage and temperature decision as a single bit.

The flags are ORed, together with the I/O supply undervoltage flag, into one combined error signal. That signal drives an active-low error pin. An enable timeout or an over-temperature condition withholds the driver enable that leaves the block. All windows are counted in clock cycles: `STABLE_CYC` for the stable-level wait and `TIMEOUT_CYC` for the enable watchdog.

Top module: `bus_fault_flags`

## Requirements
- R1: `drv_on` is high only when `mode` is normal (2'b10), `guard_en` is 1, `tx_en_n` is 0, and neither `flag_timeout` nor `flag_ot` is set. `mode` encodes 2'b00 as power off and 2'b01 or 2'b11 as low power.
- R2: While `drv_on` is high, `flag_bus_err` sets on a rising edge of `tx_data` when the previous rising edge of `tx_data` saw no rising edge of `rx_data` after it. The same rule applies to falling edges. The flag is visible after the clock edge that samples the second transmit edge.
- R3: While `drv_on` is high, a rising edge of `rx_data` that follows an unanswered rising edge of `tx_data` clears `flag_bus_err`. A falling edge that answers a falling edge does the same.
- R4: While `drv_on` is low and `mode` is not power off, `flag_bus_err`, `flag_low`, `flag_high` and `flag_short` hold their values whatever the other inputs do.
- R5: One clock in power off clears every flag, including `flag_ot` and `flag_timeout`.
- R6: Driver current flags are sampled once `tx_data` has stayed unchanged for `STABLE_CYC` active clock edges. Counting starts at the first edge with `drv_on` high, or at the edge after the edge that saw `tx_data` change. Driver index 0 is the positive-line high side, 1 the positive-line low side, 2 the negative-line high side and 3 the negative-line low side. Data 1 samples indices 0 and 3; data 0 samples indices 1 and 2. Each sampled index copies `cur_low[i]` into `flag_low[i]` and `cur_high[i]` into `flag_high[i]`. The other indices hold.
- R7: For line L (0 positive, 1 negative, with high side 2L and low side 2L+1), `flag_open[L]` is low-current on both sides. `flag_sc_vcc[L]` is low current on the high side with high current on the low side. `flag_sc_gnd[L]` is high current on the high side with low current on the low side.
- R8: `flag_short` copies `short_cmp` at the same sampling instant as R6, but only if a `tx_data` edge has been seen since `drv_on` last rose.
- R9: When the driver request (normal mode, `guard_en` 1, `tx_en_n` 0) has stood for `TIMEOUT_CYC` clock edges, `flag_timeout` sets and `drv_on` falls.
- R10: `flag_timeout` clears on any change of `tx_en_n` or `guard_en`, or on any clock with `mode` other than normal.
- R11: `flag_ot` follows `ot_cmp` only in normal mode and holds in low-power modes. While it is set, `drv_on` is low.
- R12: `err_any` is the OR of all error flags and `io_uv`, and `err_n` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Operating mode: 00 off, 10 normal, 01/11 low power |
| tx_data | input | 1 | Transmit data |
| rx_data | input | 1 | Receive data from the bus receiver |
| tx_en_n | input | 1 | Transmit enable, active low |
| guard_en | input | 1 | Guardian enable, active high |
| cur_low | input | 4 | Per-driver current below low limit |
| cur_high | input | 4 | Per-driver current above high limit |
| short_cmp | input | 1 | Differential voltage below short threshold |
| ot_cmp | input | 1 | Die temperature above limit |
| io_uv | input | 1 | I/O supply undervoltage flag |
| drv_on | output | 1 | Effective driver enable |
| flag_bus_err | output | 1 | Transmit/receive edge mismatch |
| flag_low | output | 4 | Low-current flag per driver |
| flag_high | output | 4 | High-current flag per driver |
| flag_open | output | 2 | Open line per line |
| flag_sc_vcc | output | 2 | Short to supply per line |
| flag_sc_gnd | output | 2 | Short to ground per line |
| flag_short | output | 1 | Line-to-line short |
| flag_ot | output | 1 | Over-temperature |
| flag_timeout | output | 1 | Driver enable timeout |
| err_any | output | 1 | Combined error |
| err_n | output | 1 | Error pin, active low |

## Verification
Some rules are checked on every cycle by the assertions. The gating of `drv_on` by timeout and over-temperature must hold at all times. So must the freeze of bus flags while the driver is off, the clearing of all flags in power off, the timeout clear outside normal mode, and the hold of the temperature flag in low power. Other behaviour needs stimulus with a known history, so only the bench scenarios can show it. That covers the edge-pairing rule for the bus error, the exact sampling instant and driver mapping of the current flags, the derived line faults, and the cycle on which the enable watchdog fires.

// File: rtl/bus_fault_flags_pkg.sv
`timescale 1ns/1ps
package bus_fault_flags_pkg;

    typedef enum logic [1:0] {
        MD_OFF   = 2'b00,
        MD_STBY  = 2'b01,
        MD_NORM  = 2'b10,
        MD_SLEEP = 2'b11
    } mode_e;

    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned NUM_DRV   = 2 * NUM_LINES;

    function automatic int unsigned hs_idx(input int unsigned line);
        return 2 * line;
    endfunction

    function automatic int unsigned ls_idx(input int unsigned line);
        return 2 * line + 1;
    endfunction

    // Data 1: positive line pulled up, negative line pulled down.
    function automatic logic [NUM_DRV-1:0] data1_mask();
        logic [NUM_DRV-1:0] m;
        m = '0;
        m[hs_idx(0)] = 1'b1;
        m[ls_idx(1)] = 1'b1;
        return m;
    endfunction

    // Data 0: the complementary pair of stages.
    function automatic logic [NUM_DRV-1:0] data0_mask();
        logic [NUM_DRV-1:0] m;
        m = '0;
        m[ls_idx(0)] = 1'b1;
        m[hs_idx(1)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/bus_fault_edge_err.sv
`timescale 1ns/1ps
module bus_fault_edge_err (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    input  logic tx,
    input  logic rx,
    output logic bus_err
);

    typedef struct packed {
        logic tx_prev;
        logic rx_prev;
        logic rise_pend;
        logic fall_pend;
        logic err;
    } edge_st_t;

    edge_st_t s_d, s_q;

    logic tx_r, tx_f, rx_r, rx_f;
    logic hit_set, hit_clr;

    always_comb begin
        s_d         = s_q;
        s_d.tx_prev = tx;
        s_d.rx_prev = rx;
        tx_r        = tx & ~s_q.tx_prev;
        tx_f        = ~tx & s_q.tx_prev;
        rx_r        = rx & ~s_q.rx_prev;
        rx_f        = ~rx & s_q.rx_prev;
        hit_set     = (tx_r && s_q.rise_pend && !rx_r) ||
                      (tx_f && s_q.fall_pend && !rx_f);
        hit_clr     = (rx_r && s_q.rise_pend) || (rx_f && s_q.fall_pend);
        if (clr) begin
            s_d.rise_pend = 1'b0;
            s_d.fall_pend = 1'b0;
            s_d.err       = 1'b0;
        end else if (!active) begin
            s_d.rise_pend = 1'b0;
            s_d.fall_pend = 1'b0;
        end else begin
            s_d.rise_pend = tx_r ? 1'b1 : (rx_r ? 1'b0 : s_q.rise_pend);
            s_d.fall_pend = tx_f ? 1'b1 : (rx_f ? 1'b0 : s_q.fall_pend);
            if (hit_set)      s_d.err = 1'b1;
            else if (hit_clr) s_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_err = s_q.err;

endmodule

// File: rtl/bus_fault_drv_sense.sv
`timescale 1ns/1ps
module bus_fault_drv_sense
    import bus_fault_flags_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               active,
    input  logic               tx,
    input  logic [NUM_DRV-1:0] cur_low,
    input  logic [NUM_DRV-1:0] cur_high,
    input  logic               short_cmp,
    output logic [NUM_DRV-1:0] low_flags,
    output logic [NUM_DRV-1:0] high_flags,
    output logic               short_flag
);

    localparam int unsigned CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYC - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(STABLE_CYC);

    typedef struct packed {
        logic               tx_prev;
        logic               seen_edge;
        logic [CW-1:0]      cnt;
        logic [NUM_DRV-1:0] low;
        logic [NUM_DRV-1:0] high;
        logic               short_f;
    } sense_st_t;

    sense_st_t s_d, s_q;

    logic               tx_edge;
    logic               sample;
    logic [NUM_DRV-1:0] pick;

    always_comb begin
        s_d         = s_q;
        s_d.tx_prev = tx;
        tx_edge     = tx ^ s_q.tx_prev;
        sample      = 1'b0;
        pick        = tx ? data1_mask() : data0_mask();
        if (clr) begin
            s_d.seen_edge = 1'b0;
            s_d.cnt       = '0;
            s_d.low       = '0;
            s_d.high      = '0;
            s_d.short_f   = 1'b0;
        end else if (!active) begin
            s_d.cnt       = '0;
            s_d.seen_edge = 1'b0;
        end else if (tx_edge) begin
            s_d.cnt       = '0;
            s_d.seen_edge = 1'b1;
        end else begin
            if (s_q.cnt < CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
            sample = (s_q.cnt == CNT_LAST);
        end
        if (sample) begin
            for (int i = 0; i < int'(NUM_DRV); i++) begin
                if (pick[i]) begin
                    s_d.low[i]  = cur_low[i];
                    s_d.high[i] = cur_high[i];
                end
            end
            if (s_q.seen_edge) s_d.short_f = short_cmp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign low_flags  = s_q.low;
    assign high_flags = s_q.high;
    assign short_flag = s_q.short_f;

endmodule

// File: rtl/bus_fault_en_watch.sv
`timescale 1ns/1ps
module bus_fault_en_watch #(
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_normal,
    input  logic en_req,
    input  logic tx_en_n,
    input  logic guard_en,
    output logic timeout
);

    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic          txen_prev;
        logic          guard_prev;
        logic [CW-1:0] cnt;
        logic          flag;
    } watch_st_t;

    watch_st_t s_d, s_q;
    logic ctrl_edge;

    always_comb begin
        s_d            = s_q;
        s_d.txen_prev  = tx_en_n;
        s_d.guard_prev = guard_en;
        ctrl_edge      = (tx_en_n ^ s_q.txen_prev) | (guard_en ^ s_q.guard_prev);
        if (!en_req)               s_d.cnt = '0;
        else if (ctrl_edge)        s_d.cnt = CW'(1);
        else if (s_q.cnt < CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
        if (!in_normal || ctrl_edge)
            s_d.flag = 1'b0;
        else if (en_req && s_q.cnt == CNT_LAST)
            s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{txen_prev: 1'b1, guard_prev: 1'b0, cnt: '0, flag: 1'b0};
        else        s_q <= s_d;
    end

    assign timeout = s_q.flag;

endmodule

// File: rtl/bus_fault_flags.sv
`timescale 1ns/1ps
module bus_fault_flags
    import bus_fault_flags_pkg::*;
#(
    parameter int unsigned STABLE_CYC  = 16,
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       tx_data,
    input  logic       rx_data,
    input  logic       tx_en_n,
    input  logic       guard_en,
    input  logic [3:0] cur_low,
    input  logic [3:0] cur_high,
    input  logic       short_cmp,
    input  logic       ot_cmp,
    input  logic       io_uv,
    output logic       drv_on,
    output logic       flag_bus_err,
    output logic [3:0] flag_low,
    output logic [3:0] flag_high,
    output logic [1:0] flag_open,
    output logic [1:0] flag_sc_vcc,
    output logic [1:0] flag_sc_gnd,
    output logic       flag_short,
    output logic       flag_ot,
    output logic       flag_timeout,
    output logic       err_any,
    output logic       err_n
);

    typedef struct packed {
        logic ot;
    } top_st_t;

    top_st_t t_d, t_q;

    mode_e md;
    logic  is_off, is_norm, en_req;

    assign md      = mode_e'(mode);
    assign is_off  = (md == MD_OFF);
    assign is_norm = (md == MD_NORM);
    assign en_req  = is_norm && guard_en && !tx_en_n;

    always_comb begin
        t_d = t_q;
        if (is_off)       t_d.ot = 1'b0;
        else if (is_norm) t_d.ot = ot_cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign flag_ot = t_q.ot;
    assign drv_on  = en_req && !flag_timeout && !t_q.ot;

    bus_fault_edge_err u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (is_off),
        .active  (drv_on),
        .tx      (tx_data),
        .rx      (rx_data),
        .bus_err (flag_bus_err)
    );

    bus_fault_drv_sense #(.STABLE_CYC(STABLE_CYC)) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (is_off),
        .active     (drv_on),
        .tx         (tx_data),
        .cur_low    (cur_low),
        .cur_high   (cur_high),
        .short_cmp  (short_cmp),
        .low_flags  (flag_low),
        .high_flags (flag_high),
        .short_flag (flag_short)
    );

    bus_fault_en_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_normal (is_norm),
        .en_req    (en_req),
        .tx_en_n   (tx_en_n),
        .guard_en  (guard_en),
        .timeout   (flag_timeout)
    );

    for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
        localparam int unsigned HS = 2 * ln;
        localparam int unsigned LS = 2 * ln + 1;
        assign flag_open[ln]   = flag_low[HS]  & flag_low[LS];
        assign flag_sc_vcc[ln] = flag_low[HS]  & flag_high[LS];
        assign flag_sc_gnd[ln] = flag_high[HS] & flag_low[LS];
    end

    assign err_any = flag_bus_err | (|flag_low) | (|flag_high) | flag_short |
                     flag_ot | flag_timeout | io_uv;
    assign err_n   = ~err_any;

endmodule

// File: rtl/bus_fault_flags_chk.sv
`timescale 1ns/1ps
module bus_fault_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       io_uv,
    input logic       drv_on,
    input logic       flag_bus_err,
    input logic [3:0] flag_low,
    input logic [3:0] flag_high,
    input logic       flag_short,
    input logic       flag_ot,
    input logic       flag_timeout,
    input logic       err_n
);

    logic m_off, m_norm;
    assign m_off  = (mode == 2'b00);
    assign m_norm = (mode == 2'b10);

    p_timeout_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_timeout |-> !drv_on);

    p_ot_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ot |-> !drv_on);

    p_drv_needs_norm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        drv_on |-> m_norm);

    p_freeze_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_on && !m_off) |=> ($stable(flag_bus_err) && $stable(flag_low) &&
                                 $stable(flag_high) && $stable(flag_short)));

    p_poweroff_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_off |=> (!flag_bus_err && flag_low == 4'd0 && flag_high == 4'd0 &&
                   !flag_short && !flag_ot && !flag_timeout));

    p_leave_norm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !m_norm |=> !flag_timeout);

    p_ot_hold_lp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_norm && !m_off) |=> $stable(flag_ot));

    p_uv_pin_r12: assert property (@(posedge clk) disable iff (!rst_n)
        io_uv |-> !err_n);

endmodule

bind bus_fault_flags bus_fault_flags_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .io_uv        (io_uv),
    .drv_on       (drv_on),
    .flag_bus_err (flag_bus_err),
    .flag_low     (flag_low),
    .flag_high    (flag_high),
    .flag_short   (flag_short),
    .flag_ot      (flag_ot),
    .flag_timeout (flag_timeout),
    .err_n        (err_n)
);

// File: tb/sim_bus_fault_flags.sv
`timescale 1ns/1ps
module sim_bus_fault_flags;

    localparam int unsigned S = 6;
    localparam int unsigned T = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       tx_data = 1'b0, rx_data = 1'b0, tx_en_n = 1'b1, guard_en = 1'b0;
    logic [3:0] cur_low = '0, cur_high = '0;
    logic       short_cmp = 1'b0, ot_cmp = 1'b0, io_uv = 1'b0;
    logic       drv_on, flag_bus_err, flag_short, flag_ot, flag_timeout, err_any, err_n;
    logic [3:0] flag_low, flag_high;
    logic [1:0] flag_open, flag_sc_vcc, flag_sc_gnd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_fault_flags #(.STABLE_CYC(S), .TIMEOUT_CYC(T)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tx_data(tx_data), .rx_data(rx_data),
        .tx_en_n(tx_en_n), .guard_en(guard_en), .cur_low(cur_low), .cur_high(cur_high),
        .short_cmp(short_cmp), .ot_cmp(ot_cmp), .io_uv(io_uv), .drv_on(drv_on),
        .flag_bus_err(flag_bus_err), .flag_low(flag_low), .flag_high(flag_high),
        .flag_open(flag_open), .flag_sc_vcc(flag_sc_vcc), .flag_sc_gnd(flag_sc_gnd),
        .flag_short(flag_short), .flag_ot(flag_ot), .flag_timeout(flag_timeout),
        .err_any(err_any), .err_n(err_n)
    );

    // {tx_data, rx_data, expected flag_bus_err after the edge}
    localparam logic [2:0] VEC [0:11] = '{
        3'b100, 3'b110, 3'b010, 3'b000, 3'b100, 3'b000,
        3'b101, 3'b110, 3'b011, 3'b000, 3'b100, 3'b000
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // Reset state
        chk("R5 reset flags", {flag_bus_err, flag_low, flag_high, flag_short, flag_ot, flag_timeout}, '0);
        chk("R12 reset err_n", err_n, 1);
        chk("R1 reset drv_on", drv_on, 0);

        // R1 enable decoding
        mode = 2'b10; guard_en = 1'b1; tx_en_n = 1'b0;
        step(1);
        chk("R1 enabled", drv_on, 1);
        guard_en = 1'b0; step(1);
        chk("R1 guardian low", drv_on, 0);
        guard_en = 1'b1; tx_en_n = 1'b1; step(1);
        chk("R1 tx enable high", drv_on, 0);
        mode = 2'b01; tx_en_n = 1'b0; step(1);
        chk("R1 low power", drv_on, 0);

        // R2 / R3 edge pairing table
        mode = 2'b10; step(1);
        for (int k = 0; k < 12; k++) begin
            tx_data = VEC[k][2];
            rx_data = VEC[k][1];
            step(1);
            chk($sformatf("R2 R3 vector %0d", k), flag_bus_err, VEC[k][0]);
        end

        // R6 / R7 / R8 current sampling
        tx_en_n = 1'b1; tx_data = 1'b1; rx_data = 1'b1; step(2);
        cur_low = 4'b0001; cur_high = 4'b1000; short_cmp = 1'b1;
        tx_en_n = 1'b0;
        step(S - 1);
        chk("R6 data1 before window", {flag_low, flag_high}, 8'h00);
        step(1);
        chk("R6 data1 low", flag_low, 4'b0001);
        chk("R6 data1 high", flag_high, 4'b1000);
        chk("R8 no edge no short", flag_short, 0);
        tx_data = 1'b0; rx_data = 1'b0;
        cur_low = 4'b0110; cur_high = 4'b0000;
        step(S);
        chk("R6 data0 before window", flag_low, 4'b0001);
        step(1);
        chk("R6 data0 low", flag_low, 4'b0111);
        chk("R6 data0 high kept", flag_high, 4'b1000);
        chk("R7 open line0", flag_open, 2'b01);
        chk("R7 sc vcc line1", flag_sc_vcc, 2'b10);
        chk("R7 sc gnd none", flag_sc_gnd, 2'b00);
        chk("R8 short sampled", flag_short, 1);

        // R4 frozen while driver off
        guard_en = 1'b0;
        cur_low = 4'b1111; cur_high = 4'b1111; short_cmp = 1'b0;
        step(1);
        for (int k = 0; k < 4; k++) begin
            tx_data = ~tx_data; step(2);
        end
        step(S + 2);
        chk("R4 low held", flag_low, 4'b0111);
        chk("R4 high held", flag_high, 4'b1000);
        chk("R4 short held", flag_short, 1);
        chk("R4 bus error held", flag_bus_err, 0);

        // R9 / R10 timeout
        tx_data = 1'b0; cur_low = '0; cur_high = '0; step(1);
        guard_en = 1'b1;
        step(T - 1);
        chk("R9 before timeout", {flag_timeout, drv_on}, 2'b01);
        step(1);
        chk("R9 timeout set", {flag_timeout, drv_on}, 2'b10);
        guard_en = 1'b0; step(1);
        chk("R10 clear on guard edge", flag_timeout, 0);
        guard_en = 1'b1; step(T);
        chk("R9 timeout again", flag_timeout, 1);
        mode = 2'b01; step(1);
        chk("R10 clear on leaving normal", flag_timeout, 0);

        // R11 over-temperature
        mode = 2'b10; ot_cmp = 1'b1; step(1);
        chk("R11 ot set", {flag_ot, drv_on}, 2'b10);
        mode = 2'b01; ot_cmp = 1'b0; step(2);
        chk("R11 ot held in low power", flag_ot, 1);
        mode = 2'b10; step(1);
        chk("R11 ot cleared", {flag_ot, drv_on}, 2'b01);

        // R5 power off, R12 combine
        chk("R5 flags present before off", flag_low != 4'd0, 1);
        mode = 2'b00; step(1);
        chk("R5 all cleared", {flag_bus_err, flag_low, flag_high, flag_short, flag_ot, flag_timeout}, '0);
        chk("R12 no error", {err_any, err_n}, 2'b01);
        io_uv = 1'b1; #1;
        chk("R12 uv drives pin", {err_any, err_n}, 2'b10);
        io_uv = 1'b0;
        step(2);
        finish_run();
    end

endmodule